// File: doc/BRIEF.md
# Reset Cause Classifier and Register Reset Controller

This block sits beside the core of a small 8-bit controller and decides what every incoming reset event means. Each clock it looks at the power-on request, the master-clear request, the watchdog time-out strobe, the pin-change wake strobe and the core's sleep flag. It picks at most one of six reset kinds by a fixed priority and records that kind. It then pulses two reset enables: one for the general registers of the core, and one for the control registers.

A master-clear or a watchdog time-out that arrives while the core sleeps counts as resuming execution. Such a reset leaves the general registers alone. The three cause flags in the status byte still record exactly which kind occurred, so the reset handler can branch on them. The block also holds the status byte, an option byte, a six-bit pin-direction byte and an indirect-address pointer. The core writes these through a simple write port, and the block applies the reset values of each one itself.

Top module: `rst_cause_ctrl`

## Requirements
- R1: `rst_kind` holds the code of the most recent reset: 1 power-on, 2 master-clear while running, 3 master-clear while asleep, 4 watchdog while running, 5 watchdog while asleep, 6 pin-change wake. It changes at the clock edge that samples the event. When several events coincide, the priority is power-on, then master-clear, then watchdog, then pin-change wake, with `asleep` sampled in the same cycle.
- R2: `gen_rst_en` is high in the cycle after a sampled power-on, running master-clear, running watchdog or pin-change wake event. It drops one clock after the event input is released.
- R3: A master-clear or watchdog event while `asleep` is high leaves `gen_rst_en` low.
- R4: Status bit 7 (wake flag) becomes 1 on a pin-change wake reset and 0 on every other reset kind.
- R5: Status bit 4 (time-out) and bit 3 (power-down) take these values by kind, where u means unchanged: power-on 1/1, master-clear running u/1, master-clear asleep 1/0, watchdog running 0/u, watchdog asleep 0/0, pin wake 1/0.
- R6: Every reset kind clears status bits 6:5 and keeps status bits 2:0.
- R7: Every reset kind sets `option_q` to 8'hFF and `tris_q` to 8'h3F, and raises `ctl_rst_en` for one cycle.
- R8: The upper two bits of `tris_q` always read 0, whatever is written.
- R9: The top `FSR_ONES` bits of `fsr_q` (default 2) always read 1. With the default width, power-on clears bit 5 and keeps bits 4:0. All other reset kinds keep every writable pointer bit.
- R10: A pin-change event while `asleep` is low is ignored: no reset enable, and no change to kind or status.
- R11: Writes select a register with `wr_sel`: 0 status, 1 option, 2 direction, 3 pointer. Status writes reach only bits 6:5 and 2:0. A reset in the same cycle wins over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset request, synchronous, active high |
| mclr | input | 1 | Master-clear request, active high |
| wdt_to | input | 1 | Watchdog time-out strobe |
| pin_wake | input | 1 | Pin-change wake strobe |
| asleep | input | 1 | Core is in sleep |
| wr_en | input | 1 | Core register write strobe |
| wr_sel | input | 2 | Target register of the write |
| wr_data | input | 8 | Write data |
| rst_kind | output | 3 | Code of the most recent reset |
| gen_rst_en | output | 1 | Reset enable for the general registers |
| ctl_rst_en | output | 1 | Reset enable for the control registers, any kind |
| status | output | 8 | Status byte with cause flags |
| option_q | output | 8 | Option byte |
| tris_q | output | 8 | Pin-direction byte |
| fsr_q | output | 8 | Indirect-address pointer |

## Verification
The assertions assume that `por` is high from time zero for at least one clock, and they are disabled while it stays high. They also take the event and sleep inputs to be synchronous, stable across each sampling edge. The bench meets both conditions: it drives every input on the falling edge and opens the run with two power-on cycles. The cause flags of the low status bits and the pointer are unknown until written. For that reason the bench compares those bits only after it has written them.

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl #(
  parameter int FSR_ONES = 2
) (
  input  logic       clk,
  input  logic       por,
  input  logic       mclr,
  input  logic       wdt_to,
  input  logic       pin_wake,
  input  logic       asleep,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [2:0] rst_kind,
  output logic       gen_rst_en,
  output logic       ctl_rst_en,
  output logic [7:0] status,
  output logic [7:0] option_q,
  output logic [7:0] tris_q,
  output logic [7:0] fsr_q
);

  localparam int FSR_IMP = 8 - FSR_ONES;

  localparam logic [2:0] K_NONE     = 3'd0;
  localparam logic [2:0] K_POR      = 3'd1;
  localparam logic [2:0] K_MCLR_RUN = 3'd2;
  localparam logic [2:0] K_MCLR_SLP = 3'd3;
  localparam logic [2:0] K_WDT_RUN  = 3'd4;
  localparam logic [2:0] K_WDT_SLP  = 3'd5;
  localparam logic [2:0] K_WAKE     = 3'd6;

  logic [2:0]         kind_d;
  logic               hit, gen_d, to_d, pd_d;
  logic               wake_f, to_f, pd_f;
  logic [1:0]         st_hi;
  logic [2:0]         st_lo;
  logic [7:0]         option_r;
  logic [5:0]         tris_r;
  logic [FSR_IMP-1:0] fsr_imp;

  always_comb begin
    kind_d = K_NONE;
    if (por)                      kind_d = K_POR;
    else if (mclr)                kind_d = asleep ? K_MCLR_SLP : K_MCLR_RUN;
    else if (wdt_to)              kind_d = asleep ? K_WDT_SLP : K_WDT_RUN;
    else if (pin_wake && asleep)  kind_d = K_WAKE;
  end

  assign hit   = (kind_d != K_NONE);
  assign gen_d = (kind_d == K_POR) || (kind_d == K_MCLR_RUN) ||
                 (kind_d == K_WDT_RUN) || (kind_d == K_WAKE);

  always_comb begin
    to_d = to_f;
    pd_d = pd_f;
    case (kind_d)
      K_POR:      begin to_d = 1'b1; pd_d = 1'b1; end
      K_MCLR_RUN: begin              pd_d = 1'b1; end
      K_MCLR_SLP: begin to_d = 1'b1; pd_d = 1'b0; end
      K_WDT_RUN:  begin to_d = 1'b0;              end
      K_WDT_SLP:  begin to_d = 1'b0; pd_d = 1'b0; end
      K_WAKE:     begin to_d = 1'b1; pd_d = 1'b0; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    gen_rst_en <= gen_d;
    ctl_rst_en <= hit;
    if (hit) begin
      rst_kind <= kind_d;
      wake_f   <= (kind_d == K_WAKE);
      to_f     <= to_d;
      pd_f     <= pd_d;
      st_hi    <= 2'b00;
      option_r <= 8'hFF;
      tris_r   <= 6'h3F;
      if (kind_d == K_POR && FSR_ONES < 3)
        fsr_imp[FSR_IMP-1] <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          st_hi <= wr_data[6:5];
          st_lo <= wr_data[2:0];
        end
        2'd1: option_r <= wr_data;
        2'd2: tris_r   <= wr_data[5:0];
        default: fsr_imp <= wr_data[FSR_IMP-1:0];
      endcase
    end
  end

  assign status   = {wake_f, st_hi, to_f, pd_f, st_lo};
  assign option_q = option_r;
  assign tris_q   = {2'b00, tris_r};
  assign fsr_q    = {{FSR_ONES{1'b1}}, fsr_imp};

  a_r1_por_kind: assert property (@(posedge clk) disable iff (por)
    $past(por) |-> (rst_kind == K_POR && status[4:3] == 2'b11));

  a_r1_mclr_over_wdt: assert property (@(posedge clk) disable iff (por)
    (mclr && wdt_to && !asleep) |=> (rst_kind == K_MCLR_RUN));

  a_r2_run_mclr_gen: assert property (@(posedge clk) disable iff (por)
    (mclr && !asleep) |=> gen_rst_en);

  a_r3_sleep_keep: assert property (@(posedge clk) disable iff (por)
    ((mclr || wdt_to) && asleep) |=> (!gen_rst_en && ctl_rst_en));

  a_r4_wake_flag: assert property (@(posedge clk) disable iff (por)
    ctl_rst_en |-> (status[7] == (rst_kind == K_WAKE)));

  a_r6_low_kept: assert property (@(posedge clk) disable iff (por)
    (ctl_rst_en && !$past(por)) |-> (status[2:0] == $past(status[2:0])));

  a_r7_option_ones: assert property (@(posedge clk) disable iff (por)
    ctl_rst_en |-> (option_q == 8'hFF && tris_q == 8'h3F));

  a_r10_awake_pin: assert property (@(posedge clk) disable iff (por)
    (pin_wake && !asleep && !mclr && !wdt_to) |=> !ctl_rst_en);

  a_r11_reset_wins: assert property (@(posedge clk) disable iff (por)
    (wr_en && wr_sel == 2'd1 && (mclr || wdt_to)) |=> (option_q == 8'hFF));

endmodule

// File: tb/test_rst_cause_ctrl.sv
module test_rst_cause_ctrl;
  logic clk = 1'b0;
  logic por = 1'b1, mclr = 1'b0, wdt_to = 1'b0, pin_wake = 1'b0, asleep = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rst_kind;
  logic gen_rst_en, ctl_rst_en;
  logic [7:0] status, option_q, tris_q, fsr_q;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_cause_ctrl i_rst_cause_ctrl (
    .clk(clk), .por(por), .mclr(mclr), .wdt_to(wdt_to), .pin_wake(pin_wake),
    .asleep(asleep), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rst_kind(rst_kind), .gen_rst_en(gen_rst_en), .ctl_rst_en(ctl_rst_en),
    .status(status), .option_q(option_q), .tris_q(tris_q), .fsr_q(fsr_q));

  // {mclr,wdt,pin,asleep, kind[2:0], gen, ctl, st7, to, pd}
  localparam logic [11:0] VEC [12] = '{
    12'b1000_010_11_011, 12'b0100_100_11_001, 12'b1000_010_11_001,
    12'b0101_101_01_000, 12'b0100_100_11_000, 12'b1001_011_01_010,
    12'b0011_110_11_110, 12'b1100_010_11_011, 12'b0111_101_01_000,
    12'b1011_011_01_010, 12'b0010_011_00_010, 12'b0011_110_11_110};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    check("R1 por kind", {5'd0, rst_kind}, 8'h01);
    check("R5 por status", {status[7:3], 3'b000}, 8'h18);
    check("R7 por option", option_q, 8'hFF);
    check("R7 por tris", tris_q, 8'h3F);
    check("R9 por fsr top", {fsr_q[7:5], 5'd0}, 8'hC0);
    check("R2 por gen", {6'd0, gen_rst_en, ctl_rst_en}, 8'h03);
    por = 1'b0;
    step();
    check("R2 release", {6'd0, gen_rst_en, ctl_rst_en}, 8'h00);

    for (int i = 0; i < 12; i++) begin
      {mclr, wdt_to, pin_wake, asleep} = VEC[i][11:8];
      step();
      check("R1 kind", {5'd0, rst_kind}, {5'd0, VEC[i][7:5]});
      check("R2 R3 R10 enables", {6'd0, gen_rst_en, ctl_rst_en}, {6'd0, VEC[i][4:3]});
      check("R4 R5 cause flags", {5'd0, status[7], status[4:3]}, {5'd0, VEC[i][2:0]});
      {mclr, wdt_to, pin_wake, asleep} = 4'b0000;
      step();
      check("R2 deassert", {6'd0, gen_rst_en, ctl_rst_en}, 8'h00);
    end

    wr(2'd0, 8'hFF);
    check("R11 status write mask", status, 8'hF7);
    wr(2'd1, 8'h55);
    check("R11 option write", option_q, 8'h55);
    wr(2'd2, 8'hC5);
    check("R8 tris upper zero", tris_q, 8'h05);
    wr(2'd3, 8'h00);
    check("R9 fsr fixed ones", fsr_q, 8'hC0);
    wr(2'd3, 8'h3A);
    check("R9 fsr write", fsr_q, 8'hFA);

    mclr = 1'b1; asleep = 1'b1;
    step();
    mclr = 1'b0; asleep = 1'b0;
    check("R3 sleep mclr gen", {7'd0, gen_rst_en}, 8'h00);
    check("R6 sleep status", status, 8'h17);
    check("R7 sleep option", option_q, 8'hFF);
    check("R7 sleep tris", tris_q, 8'h3F);
    check("R9 sleep fsr kept", fsr_q, 8'hFA);

    por = 1'b1;
    step();
    por = 1'b0;
    check("R6 por status low kept", status, 8'h1F);
    check("R9 por fsr", fsr_q, 8'hDA);

    wdt_to = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h12;
    step();
    wdt_to = 1'b0; wr_en = 1'b0;
    check("R11 reset beats write", option_q, 8'hFF);
    check("R1 wdt run kind", {5'd0, rst_kind}, 8'h04);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule